// File: doc/BRIEF.md
# Selectable-Lane Video Signature Accumulator

This block folds a running 16-bit CRC over a video pixel stream so that a full-rate data path can be checked against a precomputed signature. Each cycle it receives an unpacked red, green and blue pixel with a valid flag, plus a display-active flag. A control field picks one color channel and one bit lane of that channel. The chosen bit is shifted into the CRC once per valid pixel, but only during active display.

The pixel data can come from the live path or from an internal counting pattern. The pattern lets the accumulator check itself without an external image. A new accumulation begins when the hold bit of the control field falls from 1 to 0. While that bit is 1, which is the resting state, the logic is idle and the stored signature stays readable. The result is presented as a low byte and a high byte. Reset does not disturb the signature. Sync timing plays no part in the block, so it has no sync inputs.

Top module: `video_crc_sig`

## Requirements
- R1: `ctl_i[7:6]` selects the signed channel: 00 blue, 01 green, 10 red. With 11 the signature holds its value.
- R2: `ctl_i[5:3]` selects the signed bit lane of the chosen channel: value k signs bit k, from 0 to 7.
- R3: On the cycle where `ctl_i[2]` is 0 and it was 1 at the previous edge (or reset last held), the next edge clears the signature to 0x0000 and the pattern counter to 0. No bit is shifted on that edge, even if a pixel is present.
- R4: While `ctl_i[2]` is 1 the signature does not change.
- R5: `ctl_i[1]` = 0 takes the pixel inputs. `ctl_i[1]` = 1 takes a 24-bit pattern counter instead: blue = count[7:0], green = count[15:8], red = count[23:16]. The counter reads 0 after a start and advances by one after each active valid pixel while accumulation runs.
- R6: The signature only advances on edges where both `active_i` = 1 and `pix_valid_i` = 1.
- R7: Each advance computes next = (crc << 1) XOR (0x1021 if crc[15] XOR d else 0), where d is the selected bit. This is the polynomial x^16+x^12+x^5+1, fed MSB first from a seed of 0.
- R8: `sig_lo_o` carries signature bits 7..0 and `sig_hi_o` carries bits 15..8. Both are registered and change on the edge that updates the signature.
- R9: Holding `rst_ni` low leaves the signature unchanged. Reset returns the start detector to the hold=1 state and clears the pattern counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ctl_i | input | 7 | Control bits 7..1: channel [7:6], lane [5:3], hold [2], pattern source [1] (bit 0 is reserved and absent) |
| red_i | input | 8 | Red byte of the pixel |
| grn_i | input | 8 | Green byte of the pixel |
| blu_i | input | 8 | Blue byte of the pixel |
| pix_valid_i | input | 1 | Pixel present this cycle |
| active_i | input | 1 | 1 during active display, 0 during blanking |
| sig_lo_o | output | 8 | Signature bits 7..0 |
| sig_hi_o | output | 8 | Signature bits 15..8 |

## Verification
The start of a new accumulation and the arrival of an active, valid pixel can fall on the same edge. The bench provokes this by lowering the hold bit while a pixel with the selected bit set is present and display is active. The signature must then read 0x0000, not 0x1021. When the pattern source is used, the first pixel after that start must be signed from count 0. The same coincidence is repeated with the pattern source while the counter is mid-count, and a reference model judges every following cycle.

// File: rtl/vcrc_pkg.sv
// Shared types for the video signature accumulator.
// Channel codes match the index of the channel inside a packed
// [2:0][W-1:0] pixel vector (0 blue, 1 green, 2 red).
package vcrc_pkg;
    typedef enum logic [1:0] {
        CH_BLUE  = 2'b00,
        CH_GREEN = 2'b01,
        CH_RED   = 2'b10,
        CH_NONE  = 2'b11
    } chan_e;
endpackage

// File: rtl/vcrc_pattern_gen.sv
// Self-test pattern source: a 3*CH_W-bit counter split into three
// channel words (blue lowest). Assumes clear_i takes priority over
// step_i; counter is cleared by reset.
module vcrc_pattern_gen #(
    parameter int CH_W = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   clear_i,
    input  logic                   step_i,
    output logic [2:0][CH_W-1:0]   pat_o
);
    localparam int PAT_W = 3 * CH_W;

    logic [PAT_W-1:0] count_q;

    // Count active pixels; restart on clear or reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign pat_o = count_q;

    // R5
    pat_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (pat_o == '0));

    // R5
    pat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i) |=> (pat_o == $past(pat_o) + 1'b1));
endmodule

// File: rtl/vcrc_lane_select.sv
// Picks the data source (pixel or pattern), then one channel and one
// bit lane of it. Purely combinational. Assumes lane_i < CH_W.
module vcrc_lane_select
    import vcrc_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int LANE_W = $clog2(CH_W)
) (
    input  logic [2:0][CH_W-1:0] pix_i,
    input  logic [2:0][CH_W-1:0] pat_i,
    input  logic                 use_pat_i,
    input  chan_e                chan_i,
    input  logic [LANE_W-1:0]    lane_i,
    output logic                 bit_o,
    output logic                 bit_en_o
);
    logic [2:0][CH_W-1:0] src;
    logic [CH_W-1:0]      word;

    // One source multiplexer per color channel.
    for (genvar k = 0; k < 3; k++) begin : g_src
        assign src[k] = use_pat_i ? pat_i[k] : pix_i[k];
    end

    // Choose the channel word and the selected lane bit.
    always_comb begin
        unique case (chan_i)
            CH_BLUE:  word = src[0];
            CH_GREEN: word = src[1];
            CH_RED:   word = src[2];
            default:  word = '0;
        endcase
        bit_o    = word[lane_i];
        bit_en_o = (chan_i != CH_NONE);
    end
endmodule

// File: rtl/vcrc_engine.sv
// Serial CRC register with start detection. A falling hold bit
// clears the register; otherwise one bit is shifted per shift_i.
// The register is deliberately not reset: reset only freezes it and
// restores the start detector to the resting (hold=1) state.
module vcrc_engine #(
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic             start_o,
    output logic [CRC_W-1:0] crc_o
);
    logic             hold_prev_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic             fb;

    // Remember the hold bit of the previous edge; rest state is 1.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) hold_prev_q <= 1'b1;
        else         hold_prev_q <= hold_i;
    end

    assign start_o = hold_prev_q & ~hold_i;

    // One serial CRC step, MSB first.
    always_comb begin
        fb       = crc_q[CRC_W-1] ^ bit_i;
        crc_next = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Signature register: cleared on start, shifted while running.
    always_ff @(posedge clk_i) begin
        if (rst_ni) begin
            if (start_o)                 crc_q <= '0;
            else if (!hold_i && shift_i) crc_q <= crc_next;
        end
    end

    assign crc_o = crc_q;

    // R3
    start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> (crc_o == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> $stable(crc_o));

    // R6
    no_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shift_i && !start_o) |=> $stable(crc_o));

    // R7
    shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (shift_i && !hold_i && !start_o) |=>
        (crc_o[0] == ($past(crc_o[CRC_W-1]) ^ $past(bit_i))));
endmodule

// File: rtl/video_crc_sig.sv
// Top of the video signature accumulator. Decodes the control field,
// gates shifting by display-active and pixel-valid, and presents the
// signature as low and high bytes. Assumes CRC_W > 8.
module video_crc_sig
    import vcrc_pkg::*;
#(
    parameter int               CH_W  = 8,
    parameter int               CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY  = 16'h1021,
    localparam int              LANE_W  = $clog2(CH_W),
    localparam int              CTL_MSB = LANE_W + 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [CTL_MSB:1]   ctl_i,
    input  logic [CH_W-1:0]    red_i,
    input  logic [CH_W-1:0]    grn_i,
    input  logic [CH_W-1:0]    blu_i,
    input  logic               pix_valid_i,
    input  logic               active_i,
    output logic [7:0]         sig_lo_o,
    output logic [CRC_W-9:0]   sig_hi_o
);
    chan_e                chan;
    logic [LANE_W-1:0]    lane;
    logic                 hold;
    logic                 use_pat;
    logic                 pix_here;
    logic                 start;
    logic                 sel_bit;
    logic                 sel_en;
    logic [2:0][CH_W-1:0] pix_vec;
    logic [2:0][CH_W-1:0] pat_vec;
    logic [CRC_W-1:0]     crc;

    // Decode control fields and the per-pixel gate.
    always_comb begin
        chan     = chan_e'(ctl_i[CTL_MSB:CTL_MSB-1]);
        lane     = ctl_i[LANE_W+2:3];
        hold     = ctl_i[2];
        use_pat  = ctl_i[1];
        pix_here = active_i & pix_valid_i;
        pix_vec  = {red_i, grn_i, blu_i};
    end

    vcrc_pattern_gen #(.CH_W(CH_W)) u_pat (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (start),
        .step_i  (pix_here & ~hold),
        .pat_o   (pat_vec)
    );

    vcrc_lane_select #(.CH_W(CH_W), .LANE_W(LANE_W)) u_sel (
        .pix_i     (pix_vec),
        .pat_i     (pat_vec),
        .use_pat_i (use_pat),
        .chan_i    (chan),
        .lane_i    (lane),
        .bit_o     (sel_bit),
        .bit_en_o  (sel_en)
    );

    vcrc_engine #(.CRC_W(CRC_W), .POLY(POLY)) u_eng (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hold_i  (hold),
        .shift_i (pix_here & sel_en),
        .bit_i   (sel_bit),
        .start_o (start),
        .crc_o   (crc)
    );

    assign sig_lo_o = crc[7:0];
    assign sig_hi_o = crc[CRC_W-1:8];

    // R1
    no_chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chan == CH_NONE && !start) |=> $stable({sig_hi_o, sig_lo_o}));
endmodule

// File: tb/video_crc_sig_test.sv
`timescale 1ns/1ps
module video_crc_sig_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl = 8'h04;
    logic [7:0] r = '0, g = '0, b = '0;
    logic       valid = 1'b0, act = 1'b0;
    logic [7:0] sig_lo, sig_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_crc;
    logic [23:0] m_cnt;
    logic        m_prev;

    always #2.5 clk = ~clk;

    video_crc_sig uut (
        .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl[7:1]),
        .red_i(r), .grn_i(g), .blu_i(b),
        .pix_valid_i(valid), .active_i(act),
        .sig_lo_o(sig_lo), .sig_hi_o(sig_hi)
    );

    // stimulus table: {ctl, r, g, b, valid, active}
    localparam logic [33:0] VECS [0:16] = '{
        {8'h04, 8'hA5, 8'h3C, 8'h5A, 1'b1, 1'b1},  // R4 idle
        {8'h00, 8'hA5, 8'h3C, 8'h5A, 1'b1, 1'b1},  // R3 start with pixel
        {8'h00, 8'hFF, 8'h00, 8'h81, 1'b1, 1'b1},  // R1 blue lane 0
        {8'h00, 8'h12, 8'h34, 8'h57, 1'b0, 1'b1},  // R6 not valid
        {8'h00, 8'h12, 8'h34, 8'h57, 1'b1, 1'b0},  // R6 blanking
        {8'h38, 8'h00, 8'h00, 8'h80, 1'b1, 1'b1},  // R2 blue lane 7
        {8'h78, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b1},  // R1 green lane 7
        {8'h50, 8'h00, 8'h04, 8'h00, 1'b1, 1'b1},  // R2 green lane 2
        {8'h98, 8'h08, 8'h00, 8'h00, 1'b1, 1'b1},  // R1 red lane 3
        {8'hC0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R1 none selected
        {8'h02, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R5 pattern blue 0
        {8'h0A, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R5 pattern blue 1
        {8'h42, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R5 pattern green 0
        {8'h06, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R4 idle again
        {8'h02, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R3 restart pattern
        {8'h0A, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R5 count 0 lane 1
        {8'h02, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1}   // R5 count 1 lane 0
    };

    function automatic logic [15:0] ref_step(input logic [15:0] c, input logic d);
        logic fb;
        fb = c[15] ^ d;
        return {c[14:12], c[11] ^ fb, c[10:5], c[4] ^ fb, c[3:0], fb};
    endfunction

    // advance the model by one clock edge using the present inputs
    task automatic model_edge();
        logic [7:0] w;
        logic [23:0] src;
        if (!rst_n) begin
            m_prev = 1'b1;
            m_cnt  = '0;
        end else begin
            if (m_prev && !ctl[2]) begin
                m_crc = '0;
                m_cnt = '0;
            end else if (!ctl[2] && act && valid) begin
                src = ctl[1] ? m_cnt : {r, g, b};
                case (ctl[7:6])
                    2'b00: w = src[7:0];
                    2'b01: w = src[15:8];
                    2'b10: w = src[23:16];
                    default: w = 8'h00;
                endcase
                if (ctl[7:6] != 2'b11) m_crc = ref_step(m_crc, w[ctl[5:3]]);
                m_cnt = m_cnt + 1'b1;
            end
            m_prev = ctl[2];
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if ({sig_hi, sig_lo} !== m_crc) begin
            errors++;
            $display("FAIL %s: sig=%h expected %h", tag, {sig_hi, sig_lo}, m_crc);
        end
    endtask

    task automatic cycle(input logic [7:0] c, input logic [7:0] rr, gg, bb,
                         input logic v, a, input string tag);
        ctl = c; r = rr; g = gg; b = bb; valid = v; act = a;
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    task automatic expect_bytes(input logic [7:0] lo, hi, input string tag);
        checks++;
        if (sig_lo !== lo || sig_hi !== hi) begin
            errors++;
            $display("FAIL %s: lo=%h hi=%h expected lo=%h hi=%h", tag, sig_lo, sig_hi, lo, hi);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        m_prev = 1'b1;
        m_cnt  = '0;
        repeat (3) @(posedge clk);
        #1;
        m_crc = {sig_hi, sig_lo};
        rst_n = 1'b1;

        // R4: reset state is idle, signature holds under pixel traffic
        cycle(8'hC4, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, "R4 reset idle");

        // table walk, model-checked every cycle
        for (int i = 0; i < 17; i++) begin
            cycle(VECS[i][33:26], VECS[i][25:18], VECS[i][17:10], VECS[i][9:2],
                  VECS[i][1], VECS[i][0], $sformatf("R7 table[%0d]", i));
        end

        // R7 R8: known values from a zero seed
        cycle(8'h04, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R4 park");
        cycle(8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R3 start");
        expect_bytes(8'h00, 8'h00, "R3 cleared");
        cycle(8'h00, 8'h00, 8'h00, 8'h01, 1'b1, 1'b1, "R7 one");
        expect_bytes(8'h21, 8'h10, "R8 after 1");
        cycle(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R7 zero");
        expect_bytes(8'h42, 8'h20, "R8 after 10");

        // R3: start coincides with a pixel whose bit is 1
        cycle(8'h04, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, "R4 park2");
        cycle(8'h00, 8'h00, 8'h00, 8'hFF, 1'b1, 1'b1, "R3 coincident");
        expect_bytes(8'h00, 8'h00, "R3 start wins");

        // R9: reset with hold=1 leaves the signature untouched
        for (int i = 0; i < 5; i++)
            cycle(8'h00, 8'h00, 8'h00, 8'(i * 37 + 1), 1'b1, 1'b1, "R7 prefill");
        cycle(8'h04, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, "R4 park3");
        held = {sig_hi, sig_lo};
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++)
            cycle(8'h04, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, "R9 in reset");
        rst_n = 1'b1;
        checks++;
        if ({sig_hi, sig_lo} !== held) begin
            errors++;
            $display("FAIL R9: sig=%h expected %h", {sig_hi, sig_lo}, held);
        end

        // R5: long pattern run on green lane 0 (count bit 8), with gaps
        cycle(8'h42, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R3 pattern start");
        for (int i = 0; i < 700; i++)
            cycle(8'h42, 8'h00, 8'h00, 8'h00, (i % 7) != 3, (i % 11) != 5, "R5 pattern run");
        // R3 R5: restart mid-count, pixel present on the start edge
        cycle(8'h86, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R4 park4");
        cycle(8'h82, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R3 pattern restart");
        for (int i = 0; i < 40; i++)
            cycle(8'h82, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R5 red lane 0 count");
        for (int i = 0; i < 40; i++)
            cycle(8'h12, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R2 blue lane 2 count");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule